// File: doc/BRIEF.md
# Transceiver enable and protection controller

This block is the digital control side of a differential bus transceiver that can be wired for half- or full-duplex use. It takes the transmit bit, an active-high driver enable, an active-low receiver enable, two supply-good flags, an unsigned die-temperature code and a signed receiver differential voltage in millivolts. It decides when the line driver may be switched on and what polarity it drives. It also runs an over-temperature shutdown with hysteresis and turns the differential input into a clean receive bit with its own output enable.

The receiver decision window lies wholly below zero, so a line that is open, shorted or idle at 0 V reads as logic high. Inside the window the receive bit keeps its previous value, which makes the output deterministic. The driver is allowed only when both supply domains report good and no thermal shutdown is active. Every output is registered and changes one clock edge after the inputs are sampled.

Top module: `xcvr_guard`

## Requirements
- R1: While the synchronous active-low reset is asserted, every output is forced to a fixed state on the next edge: `thermShut`=0, `drvOe`=0, `drvPos`=0, `drvNeg`=0, `rxData`=1 and `rxOe`=0. This holds whatever the other inputs are.
- R2: When `drvEn`=1, both supply flags are 1 and no shutdown applies, then one edge later `drvOe`=1, `drvPos` equals the sampled `txData` and `drvNeg` is its complement.
- R3: When `drvEn`=0, one edge later `drvOe`=0 and `drvPos`=`drvNeg`=0, and `txData` has no effect on the driver pins.
- R4: When either `busPwrOk` or `logicPwrOk` is 0, one edge later `drvOe`=0 and both data pins are 0, whatever `drvEn` and `txData` are.
- R5: A sampled `dieTemp` of 150 or more (whole degrees C) sets `thermShut` on the next edge and forces `drvOe` to 0 on that same edge.
- R6: Once set, `thermShut` stays at 1 while `dieTemp` is above 140. It clears, and the driver may enable again, on the edge that samples `dieTemp` of 140 or less.
- R7: One edge after sampling, `rxOe` is 1 exactly when `rxEnN`=0 and `logicPwrOk`=1.
- R8: With `busPwrOk`=1, a differential input above -30 mV, 0 mV included, gives `rxData`=1 one edge later.
- R9: With `busPwrOk`=1, a differential input below -200 mV gives `rxData`=0 one edge later.
- R10: With `busPwrOk`=1, a differential input from -200 to -30 mV inclusive leaves `rxData` at its previous value.
- R11: With `busPwrOk`=0, `rxData` is 1 one edge later regardless of the differential input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| txData | input | 1 | Bit to transmit |
| drvEn | input | 1 | Driver enable, active high |
| rxEnN | input | 1 | Receiver output enable, active low |
| logicPwrOk | input | 1 | Logic-side supply good |
| busPwrOk | input | 1 | Bus-side supply good |
| dieTemp | input | 8 | Die temperature, unsigned whole degrees C |
| rxDiffMv | input | 16 | Receiver differential input, signed millivolts |
| drvOe | output | 1 | Line driver output enable |
| drvPos | output | 1 | Noninverting driver data (0 when disabled) |
| drvNeg | output | 1 | Inverting driver data (0 when disabled) |
| thermShut | output | 1 | Thermal shutdown active |
| rxData | output | 1 | Receive data |
| rxOe | output | 1 | Receive data output enable |

## Verification
Each output has a latency of one edge. The thermal flag, the driver pins, the receive bit and its enable all take their new value on the rising edge that samples the inputs. The bench therefore changes inputs just after a falling edge and compares at the next falling edge, exactly one register stage later. Its model steps the hysteresis and hold state in the same order as that edge. The receive-window boundaries at -30 and -200 mV and the temperature boundaries at 140 and 150 are each stepped onto directly from both sides.

// File: rtl/xcvr_guard_pkg.sv
package xcvr_guard_pkg;

  typedef enum logic [1:0] {
    ZONE_HIGH = 2'd0,
    ZONE_LOW  = 2'd1,
    ZONE_HOLD = 2'd2
  } rx_zone_e;

  typedef enum logic {
    THERM_OK   = 1'b0,
    THERM_TRIP = 1'b1
  } therm_state_e;

  // strobes from control to datapath, valid in the cycle they are sampled
  typedef struct packed {
    logic drvAllow;
    logic txBit;
    logic busLive;
    logic rxOutEn;
  } ctl_strobe_t;

endpackage

// File: rtl/xcvr_guard_ctrl.sv
module xcvr_guard_ctrl
  import xcvr_guard_pkg::*;
#(
  parameter int TEMP_W  = 8,
  parameter int TRIP_C  = 150,
  parameter int CLEAR_C = 140
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txData,
  input  logic              drvEn,
  input  logic              rxEnN,
  input  logic              logicPwrOk,
  input  logic              busPwrOk,
  input  logic [TEMP_W-1:0] dieTemp,
  output ctl_strobe_t       strobe,
  output logic              thermShut
);

  localparam logic [TEMP_W-1:0] TRIP_LIM  = TEMP_W'(TRIP_C);
  localparam logic [TEMP_W-1:0] CLEAR_LIM = TEMP_W'(CLEAR_C);

  therm_state_e thermQ;
  therm_state_e thermD;
  logic         suppliesUp;

  // hysteresis: trip at or above TRIP_LIM, release at or below CLEAR_LIM
  always_comb begin
    thermD = thermQ;
    unique case (thermQ)
      THERM_OK:   if (dieTemp >= TRIP_LIM)  thermD = THERM_TRIP;
      THERM_TRIP: if (dieTemp <= CLEAR_LIM) thermD = THERM_OK;
      default:    thermD = THERM_OK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) thermQ <= THERM_OK;
    else       thermQ <= thermD;
  end

  assign thermShut  = (thermQ == THERM_TRIP);
  assign suppliesUp = logicPwrOk & busPwrOk;

  // the driver decision uses the next thermal state so the pins and the
  // flag move on the same edge
  always_comb begin
    strobe.drvAllow = drvEn & suppliesUp & (thermD == THERM_OK);
    strobe.txBit    = txData;
    strobe.busLive  = busPwrOk;
    strobe.rxOutEn  = ~rxEnN & logicPwrOk;
  end

endmodule

// File: rtl/xcvr_guard_rxzone.sv
module xcvr_guard_rxzone
  import xcvr_guard_pkg::*;
#(
  parameter int DIFF_W = 16,
  parameter int HI_MV  = -30,
  parameter int LO_MV  = -200
) (
  input  logic signed [DIFF_W-1:0] diffMv,
  output rx_zone_e                 zone
);

  localparam logic signed [DIFF_W-1:0] HI_LIM = DIFF_W'(HI_MV);
  localparam logic signed [DIFF_W-1:0] LO_LIM = DIFF_W'(LO_MV);

  always_comb begin
    if (diffMv > HI_LIM)      zone = ZONE_HIGH;
    else if (diffMv < LO_LIM) zone = ZONE_LOW;
    else                      zone = ZONE_HOLD;
  end

endmodule

// File: rtl/xcvr_guard_datapath.sv
module xcvr_guard_datapath
  import xcvr_guard_pkg::*;
#(
  parameter int DIFF_W = 16,
  parameter int HI_MV  = -30,
  parameter int LO_MV  = -200
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctl_strobe_t              strobe,
  input  logic signed [DIFF_W-1:0] rxDiffMv,
  output logic                     drvOe,
  output logic                     drvPos,
  output logic                     drvNeg,
  output logic                     rxData,
  output logic                     rxOe
);

  rx_zone_e zone;
  logic     rxNext;

  xcvr_guard_rxzone #(
    .DIFF_W(DIFF_W),
    .HI_MV (HI_MV),
    .LO_MV (LO_MV)
  ) u_zone (
    .diffMv(rxDiffMv),
    .zone  (zone)
  );

  // an unpowered bus side reads as idle-high; the window holds state
  always_comb begin
    rxNext = rxData;
    if (!strobe.busLive) begin
      rxNext = 1'b1;
    end else begin
      unique case (zone)
        ZONE_HIGH: rxNext = 1'b1;
        ZONE_LOW:  rxNext = 1'b0;
        default:   rxNext = rxData;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      drvOe  <= 1'b0;
      drvPos <= 1'b0;
      drvNeg <= 1'b0;
      rxData <= 1'b1;
      rxOe   <= 1'b0;
    end else begin
      drvOe  <= strobe.drvAllow;
      drvPos <= strobe.drvAllow &  strobe.txBit;
      drvNeg <= strobe.drvAllow & ~strobe.txBit;
      rxData <= rxNext;
      rxOe   <= strobe.rxOutEn;
    end
  end

endmodule

// File: rtl/xcvr_guard.sv
module xcvr_guard
  import xcvr_guard_pkg::*;
#(
  parameter int TEMP_W  = 8,
  parameter int TRIP_C  = 150,
  parameter int CLEAR_C = 140,
  parameter int DIFF_W  = 16,
  parameter int HI_MV   = -30,
  parameter int LO_MV   = -200
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     txData,
  input  logic                     drvEn,
  input  logic                     rxEnN,
  input  logic                     logicPwrOk,
  input  logic                     busPwrOk,
  input  logic [TEMP_W-1:0]        dieTemp,
  input  logic signed [DIFF_W-1:0] rxDiffMv,
  output logic                     drvOe,
  output logic                     drvPos,
  output logic                     drvNeg,
  output logic                     thermShut,
  output logic                     rxData,
  output logic                     rxOe
);

  ctl_strobe_t strobe;

  xcvr_guard_ctrl #(
    .TEMP_W (TEMP_W),
    .TRIP_C (TRIP_C),
    .CLEAR_C(CLEAR_C)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .txData    (txData),
    .drvEn     (drvEn),
    .rxEnN     (rxEnN),
    .logicPwrOk(logicPwrOk),
    .busPwrOk  (busPwrOk),
    .dieTemp   (dieTemp),
    .strobe    (strobe),
    .thermShut (thermShut)
  );

  xcvr_guard_datapath #(
    .DIFF_W(DIFF_W),
    .HI_MV (HI_MV),
    .LO_MV (LO_MV)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rxDiffMv(rxDiffMv),
    .drvOe   (drvOe),
    .drvPos  (drvPos),
    .drvNeg  (drvNeg),
    .rxData  (rxData),
    .rxOe    (rxOe)
  );

endmodule

// File: rtl/xcvr_guard_chk.sv
module xcvr_guard_chk #(
  parameter int TEMP_W  = 8,
  parameter int TRIP_C  = 150,
  parameter int CLEAR_C = 140,
  parameter int DIFF_W  = 16,
  parameter int HI_MV   = -30,
  parameter int LO_MV   = -200
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     txData,
  input logic                     drvEn,
  input logic                     rxEnN,
  input logic                     logicPwrOk,
  input logic                     busPwrOk,
  input logic [TEMP_W-1:0]        dieTemp,
  input logic signed [DIFF_W-1:0] rxDiffMv,
  input logic                     drvOe,
  input logic                     drvPos,
  input logic                     drvNeg,
  input logic                     thermShut,
  input logic                     rxData,
  input logic                     rxOe
);

  localparam logic [TEMP_W-1:0]        TRIP_LIM  = TEMP_W'(TRIP_C);
  localparam logic [TEMP_W-1:0]        CLEAR_LIM = TEMP_W'(CLEAR_C);
  localparam logic signed [DIFF_W-1:0] HI_LIM    = DIFF_W'(HI_MV);
  localparam logic signed [DIFF_W-1:0] LO_LIM    = DIFF_W'(LO_MV);

  assert_drv_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    drvOe |-> $past(drvEn && logicPwrOk && busPwrOk));

  assert_drv_pair_R2: assert property (@(posedge clk) disable iff (!rstN)
    drvOe |-> (drvPos != drvNeg) && (drvPos == $past(txData)));

  assert_drv_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !drvOe |-> !drvPos && !drvNeg);

  assert_supply_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$past(busPwrOk && logicPwrOk) |-> !drvOe);

  assert_trip_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && ($past(dieTemp) >= TRIP_LIM) |-> thermShut && !drvOe);

  assert_shut_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    thermShut |-> !drvOe);

  assert_stay_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(thermShut) && ($past(dieTemp) > CLEAR_LIM) |-> thermShut);

  assert_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && ($past(dieTemp) <= CLEAR_LIM) |-> !thermShut);

  assert_rx_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> rxOe == $past(!rxEnN && logicPwrOk));

  assert_rx_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(busPwrOk) && ($past(rxDiffMv) > HI_LIM) |-> rxData);

  assert_rx_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(busPwrOk) && ($past(rxDiffMv) < LO_LIM) |-> !rxData);

  assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(busPwrOk) && ($past(rxDiffMv) <= HI_LIM)
      && ($past(rxDiffMv) >= LO_LIM) |-> $stable(rxData));

  assert_rx_busoff_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$past(busPwrOk) |-> rxData);

endmodule

bind xcvr_guard xcvr_guard_chk #(
  .TEMP_W (TEMP_W),
  .TRIP_C (TRIP_C),
  .CLEAR_C(CLEAR_C),
  .DIFF_W (DIFF_W),
  .HI_MV  (HI_MV),
  .LO_MV  (LO_MV)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .txData    (txData),
  .drvEn     (drvEn),
  .rxEnN     (rxEnN),
  .logicPwrOk(logicPwrOk),
  .busPwrOk  (busPwrOk),
  .dieTemp   (dieTemp),
  .rxDiffMv  (rxDiffMv),
  .drvOe     (drvOe),
  .drvPos    (drvPos),
  .drvNeg    (drvNeg),
  .thermShut (thermShut),
  .rxData    (rxData),
  .rxOe      (rxOe)
);

// File: tb/sim_xcvr_guard.sv
module sim_xcvr_guard;

  logic               clk = 1'b0;
  logic               rstN;
  logic               txData;
  logic               drvEn;
  logic               rxEnN;
  logic               logicPwrOk;
  logic               busPwrOk;
  logic [7:0]         dieTemp;
  logic signed [15:0] rxDiffMv;
  logic               drvOe, drvPos, drvNeg, thermShut, rxData, rxOe;

  int  checks   = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  // bench model state
  bit  mTherm = 1'b0;
  bit  mRx    = 1'b1;

  always #2ns clk = ~clk;

  xcvr_guard u0 (
    .clk       (clk),
    .rstN      (rstN),
    .txData    (txData),
    .drvEn     (drvEn),
    .rxEnN     (rxEnN),
    .logicPwrOk(logicPwrOk),
    .busPwrOk  (busPwrOk),
    .dieTemp   (dieTemp),
    .rxDiffMv  (rxDiffMv),
    .drvOe     (drvOe),
    .drvPos    (drvPos),
    .drvNeg    (drvNeg),
    .thermShut (thermShut),
    .rxData    (rxData),
    .rxOe      (rxOe)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b temp=%0d diff=%0d",
               req, what, act, exp, dieTemp, rxDiffMv);
    end
  endtask

  // inputs are already set; step the model, wait one edge, compare
  task automatic cycle();
    int    d;
    bit    eOe, eRxOe;
    string drvTag, thTag, rxTag;
    d = int'(rxDiffMv);
    if (dieTemp >= 8'd150)      mTherm = 1'b1;
    else if (dieTemp <= 8'd140) mTherm = 1'b0;
    if (!busPwrOk)      mRx = 1'b1;
    else if (d > -30)   mRx = 1'b1;
    else if (d < -200)  mRx = 1'b0;
    eOe   = drvEn && logicPwrOk && busPwrOk && !mTherm;
    eRxOe = !rxEnN && logicPwrOk;
    thTag = (dieTemp >= 8'd150) ? "R5" : "R6";
    if (!logicPwrOk || !busPwrOk) drvTag = "R4";
    else if (!drvEn)              drvTag = "R3";
    else if (mTherm)              drvTag = thTag;
    else                          drvTag = "R2";
    if (!busPwrOk)      rxTag = "R11";
    else if (d > -30)   rxTag = "R8";
    else if (d < -200)  rxTag = "R9";
    else                rxTag = "R10";
    @(negedge clk);
    check(thTag,  "thermShut", thermShut, mTherm);
    check(drvTag, "drvOe",     drvOe,     eOe);
    check(drvTag, "drvPos",    drvPos,    eOe & txData);
    check(drvTag, "drvNeg",    drvNeg,    eOe & ~txData);
    check(rxTag,  "rxData",    rxData,    mRx);
    check("R7",   "rxOe",      rxOe,      eRxOe);
  endtask

  initial begin
    // reset with inputs that would otherwise move every output
    rstN = 1'b0; txData = 1'b1; drvEn = 1'b1; rxEnN = 1'b0;
    logicPwrOk = 1'b1; busPwrOk = 1'b1; dieTemp = 8'd200; rxDiffMv = -16'sd500;
    repeat (3) @(negedge clk);
    check("R1", "thermShut", thermShut, 1'b0);
    check("R1", "drvOe",     drvOe,     1'b0);
    check("R1", "drvPos",    drvPos,    1'b0);
    check("R1", "drvNeg",    drvNeg,    1'b0);
    check("R1", "rxData",    rxData,    1'b1);
    check("R1", "rxOe",      rxOe,      1'b0);
    dieTemp = 8'd25; rxDiffMv = 16'sd100;
    rstN = 1'b1;
    mTherm = 1'b0; mRx = 1'b1;

    // driver and supply truth table, both receiver enables
    for (int i = 0; i < 32; i++) begin
      {rxEnN, txData, drvEn, logicPwrOk, busPwrOk} = 5'(i);
      cycle();
    end

    // thermal ramp across trip, hold band and release
    logicPwrOk = 1'b1; busPwrOk = 1'b1; drvEn = 1'b1; rxEnN = 1'b0;
    for (int t = 130; t <= 160; t++) begin
      dieTemp = 8'(t); txData = t[0]; cycle();
    end
    for (int t = 160; t >= 120; t--) begin
      dieTemp = 8'(t); txData = t[1]; cycle();
    end
    for (int t = 138; t <= 149; t++) begin
      dieTemp = 8'(t); txData = t[0]; cycle();
    end
    foreach (dieTemp[k]) begin
      dieTemp = (k % 2 == 0) ? 8'd255 : 8'd0; txData = ~txData; cycle();
    end
    dieTemp = 8'd150; cycle();
    dieTemp = 8'd141; cycle();
    dieTemp = 8'd140; cycle();
    dieTemp = 8'd25;  cycle();

    // receiver sweep down and back up through the window
    for (int d = 100; d >= -300; d--) begin
      rxDiffMv = 16'(d); cycle();
    end
    for (int d = -300; d <= 100; d++) begin
      rxDiffMv = 16'(d); cycle();
    end

    // targeted boundary and supply-loss steps
    begin
      int pat [12] = '{-201, -200, -30, -29, -31, -250, -100, 0, -100, -200, 32767, -32768};
      foreach (pat[j]) begin
        rxDiffMv = 16'(pat[j]); cycle();
      end
    end
    busPwrOk = 1'b0; rxDiffMv = -16'sd500; cycle();
    cycle();
    busPwrOk = 1'b1; rxDiffMv = -16'sd100; cycle();
    rxDiffMv = -16'sd250; cycle();
    busPwrOk = 1'b0; rxDiffMv = -16'sd100; cycle();
    busPwrOk = 1'b1; cycle();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200us;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule